// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a single-rank DDR2 device from power-up to normal operation. A start pulse launches a fixed run of memory commands: a NOP with clock enable asserted, a long settling wait, precharge-all, DLL enable and DLL reset mode loads, a second precharge-all, eight auto-refresh commands, the operating mode load (burst length 8, CAS latency 5, write recovery 5), the two off-chip-driver calibration loads (default, then exit) and finally the normal-operation command. All intervals are counted in controller clocks. The cycles per microsecond come from a 3-bit DRAM clock code that is captured when the run starts.

Each command appears for one cycle on a command strobe. The 3-bit command field keeps its value between commands. Every mode load also shows an 18-bit word: the low 16 bits go out on the row address and the two bits above them go out on the mode-register bank select. Page mode and the refresh interval stay off until normal operation begins. The block also derives the rank size from two bytes of the module description.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset the block is idle: `cs_n`=1, `cke`=0, `cmd_valid`=0, `busy`=0, `done`=0, `error`=0, `page_mode_en`=0 and `refresh_interval`=0.
- R2: A start sampled while idle with a legal code issues the NOP on the next cycle, with `cke`=1 and `cs_n`=0 from that cycle onward. Seventeen commands follow in this order: NOP, precharge, mode, mode, precharge, eight refreshes, mode, mode, mode, normal.
- R3: The command codes are normal=000, NOP=001, precharge=010, mode load=011 and refresh=100. `cmd` changes only in a cycle where `cmd_valid` is 1.
- R4: The strobes are spaced as follows. NOP to the next command is `INIT_US`×C cycles. Refresh to the next refresh is `REF_US`×C cycles. Every other pair is `GAP_CYCLES` cycles. C is the cycles-per-microsecond value.
- R5: Exactly eight refresh strobes are issued per run.
- R6: The mode loads present, in order, the words 0x02000, 0x00800, 0x022D8, 0x21C20 and 0x20020, with `row_addr`=word[15:0] and `bank_sel`=word[17:16]. Every other command presents zero on both.
- R7: C is 100, 133, 166, 200, 266 or 333 for codes 000 to 101. It is captured at start, and later changes to `freq_code` have no effect.
- R8: A start with code 110 or 111 sets `error`=1 and issues no command. The block stays in this state until reset, and further starts are ignored.
- R9: `busy` is 1 from the NOP cycle until the normal command. Start pulses while busy, and after done, are ignored.
- R10: `done`, `page_mode_en`=1 and `refresh_interval`=0x32 appear together in the cycle of the normal command. Before that cycle they read 0.
- R11: `rank_size` = (density>>1 if density>=0x10, else density<<1) × (banks/4), truncated to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the sequence (honoured only while idle) |
| freq_code | input | 3 | DRAM clock code, captured at start |
| spd_density | input | 8 | Row density byte from the module description |
| spd_banks | input | 8 | Banks-per-device byte from the module description |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Normal operation reached |
| error | output | 1 | Reserved clock code seen at start |
| cmd_valid | output | 1 | One-cycle strobe for each issued command |
| cmd | output | 3 | Current command field |
| row_addr | output | 16 | Row address of the current command |
| bank_sel | output | 2 | Mode-register bank select of the current command |
| cs_n | output | 1 | Chip select, active low |
| cke | output | 1 | Clock enable |
| page_mode_en | output | 1 | Multipage mode enable |
| refresh_interval | output | 8 | Refresh interval value, zero until done |
| rank_size | output | 8 | Computed rank size |

## Verification
Some properties are checked by assertions on every cycle. The command field must not change without a strobe. Clock enable must never drop once it is raised. Non-mode commands must carry a zero address. An errored block must stay silent. Busy, done and error must be mutually exclusive. Page mode must appear only with done. At most eight refreshes may be issued, and exactly eight must have been issued once done is reached. The timer must never be loaded with zero. Other behaviour depends on the clock code and can only be shown by the bench scenarios, which compare every cycle against a schedule built from the requirements. These are the exact command spacing for each code, the full mode-word order, the capture of the code at start, start pulses that are ignored mid-run and after done, and the rank-size arithmetic.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  localparam int ROW_W      = 16;
  localparam int WORD_W     = ROW_W + 2;
  localparam int STEP_W     = 5;
  localparam int LAST_STEP  = 16;
  localparam int REF_TOTAL  = 8;
  localparam int MAX_CPU    = 333;

  typedef enum logic [2:0] {
    CMD_NORMAL    = 3'b000,
    CMD_NOP       = 3'b001,
    CMD_PRECHARGE = 3'b010,
    CMD_MODE      = 3'b011,
    CMD_REFRESH   = 3'b100
  } dram_cmd_e;

  typedef enum logic [1:0] {
    GAP_SHORT,
    GAP_POWERUP,
    GAP_REFRESH
  } gap_kind_e;

  localparam logic [WORD_W-1:0] WORD_DLL_ON    = 18'h02000;
  localparam logic [WORD_W-1:0] WORD_DLL_RESET = 18'h00800;
  localparam logic [WORD_W-1:0] WORD_OPERATE   = 18'h022D8;
  localparam logic [WORD_W-1:0] WORD_OCD_DFLT  = 18'h21C20;
  localparam logic [WORD_W-1:0] WORD_OCD_EXIT  = 18'h20020;

  function automatic logic freq_code_ok(input logic [2:0] code);
    return code <= 3'b101;
  endfunction

  function automatic logic [8:0] cycles_per_us(input logic [2:0] code);
    case (code)
      3'b000:  return 9'd100;
      3'b001:  return 9'd133;
      3'b010:  return 9'd166;
      3'b011:  return 9'd200;
      3'b100:  return 9'd266;
      3'b101:  return 9'd333;
      default: return 9'd0;
    endcase
  endfunction

  function automatic int wait_len(input gap_kind_e kind, input logic [8:0] cpu,
                                  input int init_us, input int ref_us, input int gap);
    case (kind)
      GAP_POWERUP: return init_us * int'(cpu);
      GAP_REFRESH: return ref_us * int'(cpu);
      default:     return gap;
    endcase
  endfunction

  function automatic logic [7:0] rank_size_calc(input logic [7:0] density,
                                                input logic [7:0] banks);
    logic [7:0]  scaled;
    logic [15:0] prod;
    scaled = (density >= 8'h10) ? (density >> 1) : (density << 1);
    prod   = {8'd0, scaled} * {10'd0, banks[7:2]};
    return prod[7:0];
  endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  a_r4_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> load_val != '0);

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/ddr2_init_step_rom.sv
module ddr2_init_step_rom
  import ddr2_init_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output dram_cmd_e         step_cmd,
  output logic [WORD_W-1:0] step_word,
  output gap_kind_e         step_gap
);

  always_comb begin
    step_cmd  = CMD_NORMAL;
    step_word = '0;
    step_gap  = GAP_SHORT;
    case (step) inside
      5'd0:           begin step_cmd = CMD_NOP; step_gap = GAP_POWERUP; end
      5'd1, 5'd4:     step_cmd = CMD_PRECHARGE;
      5'd2:           begin step_cmd = CMD_MODE; step_word = WORD_DLL_ON;    end
      5'd3:           begin step_cmd = CMD_MODE; step_word = WORD_DLL_RESET; end
      [5'd5:5'd11]:   begin step_cmd = CMD_REFRESH; step_gap = GAP_REFRESH; end
      5'd12:          step_cmd = CMD_REFRESH;
      5'd13:          begin step_cmd = CMD_MODE; step_word = WORD_OPERATE;  end
      5'd14:          begin step_cmd = CMD_MODE; step_word = WORD_OCD_DFLT; end
      5'd15:          begin step_cmd = CMD_MODE; step_word = WORD_OCD_EXIT; end
      default:        step_cmd = CMD_NORMAL;
    endcase
  end

endmodule

// File: rtl/ddr2_rank_size.sv
module ddr2_rank_size
  import ddr2_init_pkg::*;
(
  input  logic [7:0] density,
  input  logic [7:0] banks,
  output logic [7:0] size
);

  assign size = rank_size_calc(density, banks);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int         INIT_US      = 200,
  parameter int         REF_US       = 100,
  parameter int         GAP_CYCLES   = 4,
  parameter logic [7:0] REFRESH_LOAD = 8'h32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  freq_code,
  input  logic [7:0]  spd_density,
  input  logic [7:0]  spd_banks,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        cmd_valid,
  output logic [2:0]  cmd,
  output logic [15:0] row_addr,
  output logic [1:0]  bank_sel,
  output logic        cs_n,
  output logic        cke,
  output logic        page_mode_en,
  output logic [7:0]  refresh_interval,
  output logic [7:0]  rank_size
);

  localparam int LONG_US = (INIT_US > REF_US) ? INIT_US : REF_US;
  localparam int MAX_WAIT = MAX_CPU * LONG_US + GAP_CYCLES;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE, S_ERR} seq_state_e;

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [8:0]        cpu_q;
  logic [2:0]        cmd_q;
  logic [15:0]       row_q;
  logic [1:0]        bank_q;
  logic              valid_q, cs_n_q, cke_q;

  // internal events, named for the assertions
  logic              start_ok, start_bad, step_due, issue;
  logic [STEP_W-1:0] issue_step;
  logic [8:0]        cpu_sel;
  dram_cmd_e         rom_cmd;
  logic [WORD_W-1:0] rom_word;
  gap_kind_e         rom_gap;
  logic              tmr_zero;
  logic [CNT_W-1:0]  tmr_val;

  assign start_ok   = (state_q == S_IDLE) && start &&  freq_code_ok(freq_code);
  assign start_bad  = (state_q == S_IDLE) && start && !freq_code_ok(freq_code);
  assign step_due   = (state_q == S_RUN) && tmr_zero;
  assign issue      = start_ok || step_due;
  assign issue_step = (state_q == S_IDLE) ? '0 : step_q + 1'b1;
  assign cpu_sel    = (state_q == S_IDLE) ? cycles_per_us(freq_code) : cpu_q;
  assign tmr_val    = CNT_W'(wait_len(rom_gap, cpu_sel, INIT_US, REF_US, GAP_CYCLES));

  ddr2_init_step_rom u_rom (
    .step      (issue_step),
    .step_cmd  (rom_cmd),
    .step_word (rom_word),
    .step_gap  (rom_gap)
  );

  ddr2_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ddr2_rank_size u_size (
    .density (spd_density),
    .banks   (spd_banks),
    .size    (rank_size)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      cpu_q   <= '0;
    end else begin
      if (start_bad) state_q <= S_ERR;
      if (start_ok) begin
        state_q <= S_RUN;
        cpu_q   <= cycles_per_us(freq_code);
      end
      if (issue) begin
        step_q <= issue_step;
        if (issue_step == STEP_W'(LAST_STEP)) state_q <= S_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cmd_q   <= CMD_NORMAL;
      row_q   <= '0;
      bank_q  <= '0;
      cs_n_q  <= 1'b1;
      cke_q   <= 1'b0;
    end else begin
      valid_q <= issue;
      if (issue) begin
        cmd_q  <= rom_cmd;
        row_q  <= rom_word[ROW_W-1:0];
        bank_q <= rom_word[WORD_W-1:ROW_W];
        cs_n_q <= 1'b0;
        cke_q  <= 1'b1;
      end
    end
  end

  assign busy             = (state_q == S_RUN);
  assign done             = (state_q == S_DONE);
  assign error            = (state_q == S_ERR);
  assign cmd_valid        = valid_q;
  assign cmd              = cmd_q;
  assign row_addr         = row_q;
  assign bank_sel         = bank_q;
  assign cs_n             = cs_n_q;
  assign cke              = cke_q;
  assign page_mode_en     = done;
  assign refresh_interval = done ? REFRESH_LOAD : 8'h00;

  // refresh strobes seen at the outputs, for the R5 checks
  logic [3:0] ref_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_seen_q <= '0;
    else if (cmd_valid && cmd == CMD_REFRESH) ref_seen_q <= ref_seen_q + 1'b1;
  end

  a_r3_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd));

  a_r2_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cke));

  a_r2_first_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_valid && cmd == CMD_NOP && cke && !cs_n));

  a_r6_plain_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd != CMD_MODE) |-> (row_addr == '0 && bank_sel == '0));

  a_r8_error_silent: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!cmd_valid && !busy && !done));

  a_r9_states_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, error}));

  a_r10_page_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (page_mode_en || refresh_interval != 8'h00) |-> done);

  a_r5_refresh_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ref_seen_q <= 4'(REF_TOTAL));

  a_r5_eight_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |=> ref_seen_q == 4'(REF_TOTAL));

endmodule

// File: tb/ddr2_init_seq_bench.sv
module ddr2_init_seq_bench;

  localparam int T_INIT = 2;
  localparam int T_REF  = 1;
  localparam int T_GAP  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  freq_code = 3'b000;
  logic [7:0]  spd_density = 8'h00;
  logic [7:0]  spd_banks = 8'h00;
  logic        busy, done, error, cmd_valid, cs_n, cke, page_mode_en;
  logic [2:0]  cmd;
  logic [15:0] row_addr;
  logic [1:0]  bank_sel;
  logic [7:0]  refresh_interval, rank_size;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ddr2_init_seq #(.INIT_US(T_INIT), .REF_US(T_REF), .GAP_CYCLES(T_GAP)) u_ddr2_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_code(freq_code),
    .spd_density(spd_density), .spd_banks(spd_banks),
    .busy(busy), .done(done), .error(error), .cmd_valid(cmd_valid), .cmd(cmd),
    .row_addr(row_addr), .bank_sel(bank_sel), .cs_n(cs_n), .cke(cke),
    .page_mode_en(page_mode_en), .refresh_interval(refresh_interval),
    .rank_size(rank_size)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int mhz_of(input logic [2:0] code);
    int tbl[6] = '{100, 133, 166, 200, 266, 333};
    return tbl[code];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // expected schedule, built from the requirements
  int q_cmd[$];
  int q_word[$];
  int q_gap[$];

  task automatic build_schedule(input int mhz);
    q_cmd.delete(); q_word.delete(); q_gap.delete();
    q_cmd.push_back(1); q_word.push_back(0); q_gap.push_back(T_INIT * mhz);
    q_cmd.push_back(2); q_word.push_back(0); q_gap.push_back(T_GAP);
    q_cmd.push_back(3); q_word.push_back('h02000); q_gap.push_back(T_GAP);
    q_cmd.push_back(3); q_word.push_back('h00800); q_gap.push_back(T_GAP);
    q_cmd.push_back(2); q_word.push_back(0); q_gap.push_back(T_GAP);
    for (int r = 0; r < 8; r++) begin
      q_cmd.push_back(4); q_word.push_back(0);
      q_gap.push_back((r == 7) ? T_GAP : T_REF * mhz);
    end
    q_cmd.push_back(3); q_word.push_back('h022D8); q_gap.push_back(T_GAP);
    q_cmd.push_back(3); q_word.push_back('h21C20); q_gap.push_back(T_GAP);
    q_cmd.push_back(3); q_word.push_back('h20020); q_gap.push_back(T_GAP);
    q_cmd.push_back(0); q_word.push_back(0); q_gap.push_back(0);
  endtask

  task automatic run_seq(input logic [2:0] code, input bit poke, input bit alter);
    int refs = 0;
    build_schedule(mhz_of(code));
    freq_code = code;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (alter) freq_code = 3'b000;   // R7: must not change the spacing
    for (int k = 0; k < q_cmd.size(); k++) begin
      if (k > 0) begin
        for (int i = 1; i < q_gap[k-1]; i++) begin
          chk(!cmd_valid && busy && !done && !page_mode_en, "R4/R9/R10 quiet wait",
              {cmd_valid, busy, done, page_mode_en}, 4'b0100);
          if (poke && k == 3 && i == 1) start = 1'b1;
          @(negedge clk);
          if (poke && k == 3 && i == 1) start = 1'b0;
        end
        if (q_gap[k-1] <= 1) @(negedge clk);
      end
      chk(cmd_valid === 1'b1, "R4 strobe timing", cmd_valid, 1);
      chk(cmd == 3'(q_cmd[k]), "R2/R3 command order", cmd, q_cmd[k]);
      chk(row_addr == q_word[k][15:0], "R6 row address", row_addr, q_word[k] & 'hFFFF);
      chk(bank_sel == 2'(q_word[k] >> 16), "R6 bank select", bank_sel, q_word[k] >> 16);
      chk(cke && !cs_n, "R2 cke/cs_n asserted", {cke, cs_n}, 2'b10);
      if (cmd == 3'b100) refs++;
      if (k < q_cmd.size() - 1) begin
        chk(busy && !done && refresh_interval == 8'h00, "R9/R10 busy during run",
            {busy, done, refresh_interval}, 10'h200);
        if (k < q_cmd.size() - 1) @(negedge clk);
      end
    end
    chk(refs == 8, "R5 refresh count", refs, 8);
    chk(done && !busy && page_mode_en && refresh_interval == 8'h32, "R10 post-init enables",
        {done, busy, page_mode_en, refresh_interval}, {3'b101, 8'h32});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk(!cmd_valid && done, "R9 start after done ignored", {cmd_valid, done}, 2'b01);
      @(negedge clk);
    end
  endtask

  initial begin
    while (!finished && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(cs_n && !cke && !cmd_valid && !busy && !done && !error, "R1 reset outputs",
        {cs_n, cke, cmd_valid, busy, done, error}, 6'b100000);
    chk(!page_mode_en && refresh_interval == 8'h00, "R1 reset enables",
        {page_mode_en, refresh_interval}, 0);
    repeat (5) @(negedge clk);
    chk(!cmd_valid && !busy && cs_n, "R9 idle without start", {cmd_valid, busy, cs_n}, 3'b001);

    // R11 rank size
    spd_density = 8'h20; spd_banks = 8'd8; #1;
    chk(rank_size == 8'h20, "R11 large density dual", rank_size, 8'h20);
    spd_density = 8'h08; spd_banks = 8'd4; #1;
    chk(rank_size == 8'h10, "R11 small density single", rank_size, 8'h10);
    spd_density = 8'h80; spd_banks = 8'd8; #1;
    chk(rank_size == 8'h80, "R11 top density dual", rank_size, 8'h80);
    spd_density = 8'h10; spd_banks = 8'd4; #1;
    chk(rank_size == 8'h08, "R11 boundary 0x10", rank_size, 8'h08);

    // R8 reserved codes
    for (int c = 6; c < 8; c++) begin
      do_reset();
      freq_code = 3'(c);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      freq_code = 3'b000;
      chk(error && !busy, "R8 error on reserved code", {error, busy}, 2'b10);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 8; i++) begin
        chk(error && !cmd_valid && cs_n && !cke, "R8 error holds, no commands",
            {error, cmd_valid, cs_n, cke}, 4'b1010);
        @(negedge clk);
      end
    end

    // full runs (R2-R7, R9, R10)
    do_reset();
    run_seq(3'b000, 1'b1, 1'b0);
    do_reset();
    run_seq(3'b101, 1'b0, 1'b0);
    do_reset();
    run_seq(3'b011, 1'b1, 1'b1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule